// File: doc/BRIEF.md
# Interrupt Mask and Priority Selector

This block sits between the interrupt inputs of a processor core and its exception entry logic. Each cycle it examines the pending physical and virtual interrupt requests and the masking state of the core. It then names the single exception the core should take next: a one-cycle-registered take strobe plus an exception index. It also produces a has-work indication that wakes a halted core whenever any enabled request is pending and the core is powered.

Three physical request classes exist: ordinary IRQ, FIQ and a superpriority NMI. Each is checked against its own target exception level. When the NMI feature is built in, an all-interrupts mask condition takes part in the check. It is tied to the current level, the target level's control bits and the stack-pointer select, and it masks the NMI and also gates IRQ and FIQ. Virtual IRQ, FIQ and NMI pass through unmasked. With the feature parameter cleared, none of the NMI logic is built, and NMI and virtual-NMI lines are ignored.

Top module: `excp_select`

## Requirements
- R1: A synchronous active-high reset clears all pending state. While reset is high and in the cycle after it, take_o, excp_idx_o and has_work_o are 0.
- R2: With the feature built in, the NMI mask condition holds only when the current level equals the class's target level. It then holds if (the target level's NMI-control bit AND allint_i) OR (the target level's SP-mask bit AND sp_sel_i). A pending NMI is taken only when this condition is false.
- R3: IRQ is taken only when irq_mask_i is 0 and the mask condition of R2 is false for IRQ's target level. FIQ is taken likewise with fiq_mask_i.
- R4: A physical request whose target level is below cur_lvl_i is never taken, whatever the mask bits are.
- R5: With the feature built in, an unmasked pending NMI wins over every other request, including FIQ.
- R6: With FEAT_NMI=0 the mask condition is treated as false. Lines 4 (NMI) and 5 (virtual NMI) are neither selected nor counted for has-work.
- R7: has_work_o is 1 exactly when pwr_off_i is 0 and at least one enabled request is pending: lines 0 to 3, the virtual-SError request, the exit request, and lines 4 and 5 when the feature is built in.
- R8: After NMI, priority is FIQ, IRQ, virtual FIQ, virtual IRQ, then virtual NMI. Virtual lines are taken whenever pending. Only the highest eligible request is reported. Index codes: IRQ=5, FIQ=6, virtual IRQ=14, virtual FIQ=15, NMI=26, virtual NMI=27.
- R9: Request lines are level-sensitive, bit 0 IRQ, 1 FIQ, 2 virtual IRQ, 3 virtual FIQ, 4 NMI, 5 virtual NMI. Each is sampled into a pending register at every edge. take_o and excp_idx_o, registered at the next edge, use that pending state with the mask inputs present at that edge. Dropping a line removes it two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | 6 | Level request lines, encoding in R9 |
| vserr_req_i | input | 1 | Virtual SError request (has-work only) |
| exit_req_i | input | 1 | Exit request (has-work only) |
| pwr_off_i | input | 1 | Core powered off |
| cur_lvl_i | input | LVL_W | Current exception level |
| tgt_lvl_i | input | 3*LVL_W | Target levels: [0] IRQ, [1] FIQ, [2] NMI |
| irq_mask_i | input | 1 | IRQ mask bit from processor state |
| fiq_mask_i | input | 1 | FIQ mask bit from processor state |
| allint_i | input | 1 | All-interrupts mask bit |
| sp_sel_i | input | 1 | Stack-pointer select bit |
| nmi_ctl_i | input | NUM_LVL | Per-level NMI control bit |
| spmask_ctl_i | input | NUM_LVL | Per-level SP-interrupt-mask bit |
| take_o | output | 1 | Take-exception strobe |
| excp_idx_o | output | IDX_W | Exception index of the taken request |
| has_work_o | output | 1 | Wake-up indication |

## Verification
The hardest situation to reach is an NMI masked by the SP-select term alone, with allint clear. It needs the current and target levels equal and the SP-mask control set for exactly that level. A second hard case is the same condition blocking IRQ while leaving virtual lines through. Directed phases set these level and control combinations explicitly. A long random phase then covers the rest. A behavioural model drives two instances, one with and one without the NMI feature, from identical stimulus.

// File: rtl/excp_sel_pkg.sv
package excp_sel_pkg;
  localparam int NUM_LINES = 6;
  localparam int LN_IRQ  = 0;
  localparam int LN_FIQ  = 1;
  localparam int LN_VIRQ = 2;
  localparam int LN_VFIQ = 3;
  localparam int LN_NMI  = 4;
  localparam int LN_VNMI = 5;

  localparam int NUM_CLS = 3;
  localparam int CL_IRQ = 0;
  localparam int CL_FIQ = 1;
  localparam int CL_NMI = 2;

  localparam int CODE_IRQ  = 5;
  localparam int CODE_FIQ  = 6;
  localparam int CODE_VIRQ = 14;
  localparam int CODE_VFIQ = 15;
  localparam int CODE_NMI  = 26;
  localparam int CODE_VNMI = 27;
endpackage

// File: rtl/excp_pend.sv
module excp_pend
  import excp_sel_pkg::*;
#(
  parameter bit FEAT_NMI = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 vserr_i,
  input  logic                 exit_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic                 side_pend_o
);
  localparam logic [NUM_LINES-1:0] LINE_EN =
    FEAT_NMI ? {NUM_LINES{1'b1}} : ~((NUM_LINES'(1) << LN_NMI) | (NUM_LINES'(1) << LN_VNMI));

  logic [NUM_LINES-1:0] pend_q;
  logic                 side_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      side_q <= 1'b0;
    end else begin
      pend_q <= lines_i & LINE_EN;
      side_q <= vserr_i | exit_i;
    end
  end

  assign pend_o      = pend_q;
  assign side_pend_o = side_q;

  generate
    if (!FEAT_NMI) begin : g_chk_gate
      always_ff @(posedge clk) begin
        if (!rst) begin
          AST_NMI_NEVER_PENDS: assert (!pend_q[LN_NMI] && !pend_q[LN_VNMI]); // R6
        end
      end
    end
  endgenerate
endmodule

// File: rtl/excp_mask.sv
module excp_mask
  import excp_sel_pkg::*;
#(
  parameter int NUM_LVL  = 4,
  parameter int LVL_W    = 2,
  parameter bit FEAT_NMI = 1'b1
) (
  input  logic [LVL_W-1:0]         cur_lvl_i,
  input  logic [NUM_CLS*LVL_W-1:0] tgt_lvl_i,
  input  logic                     irq_mask_i,
  input  logic                     fiq_mask_i,
  input  logic                     allint_i,
  input  logic                     sp_sel_i,
  input  logic [NUM_LVL-1:0]       nmi_ctl_i,
  input  logic [NUM_LVL-1:0]       spmask_ctl_i,
  output logic [NUM_CLS-1:0]       allow_o
);
  generate
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      logic [LVL_W-1:0] tl;
      logic             below;
      logic             same;
      logic             nmi_block;
      logic             own_mask;

      assign tl    = tgt_lvl_i[c*LVL_W +: LVL_W];
      assign below = tl < cur_lvl_i;
      assign same  = tl == cur_lvl_i;

      if (FEAT_NMI) begin : g_nmi
        logic ctl_bit;
        logic sp_bit;
        always_comb begin
          ctl_bit = 1'b0;
          sp_bit  = 1'b0;
          for (int k = 0; k < NUM_LVL; k++) begin
            if (tl == LVL_W'(k)) begin
              ctl_bit = nmi_ctl_i[k];
              sp_bit  = spmask_ctl_i[k];
            end
          end
        end
        assign nmi_block = same & ((ctl_bit & allint_i) | (sp_bit & sp_sel_i));
      end else begin : g_no_nmi
        assign nmi_block = 1'b0;
      end

      if (c == CL_IRQ) begin : g_irq
        assign own_mask = irq_mask_i;
      end else if (c == CL_FIQ) begin : g_fiq
        assign own_mask = fiq_mask_i;
      end else begin : g_nmi_cls
        assign own_mask = 1'b0;
      end

      assign allow_o[c] = !below && !own_mask && !nmi_block;
    end
  endgenerate
endmodule

// File: rtl/excp_prio.sv
module excp_prio
  import excp_sel_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter bit FEAT_NMI = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic                 side_pend_i,
  input  logic [NUM_CLS-1:0]   allow_i,
  input  logic                 pwr_off_i,
  output logic                 take_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 work_o
);
  logic [NUM_LINES-1:0] elig;
  logic                 take_d;
  logic [IDX_W-1:0]     idx_d;
  logic                 work_d;

  always_comb begin
    elig          = '0;
    elig[LN_IRQ]  = pend_i[LN_IRQ] & allow_i[CL_IRQ];
    elig[LN_FIQ]  = pend_i[LN_FIQ] & allow_i[CL_FIQ];
    elig[LN_VIRQ] = pend_i[LN_VIRQ];
    elig[LN_VFIQ] = pend_i[LN_VFIQ];
    elig[LN_NMI]  = FEAT_NMI & pend_i[LN_NMI] & allow_i[CL_NMI];
    elig[LN_VNMI] = FEAT_NMI & pend_i[LN_VNMI];
  end

  always_comb begin
    take_d = 1'b1;
    idx_d  = '0;
    if (elig[LN_NMI])       idx_d = IDX_W'(CODE_NMI);
    else if (elig[LN_FIQ])  idx_d = IDX_W'(CODE_FIQ);
    else if (elig[LN_IRQ])  idx_d = IDX_W'(CODE_IRQ);
    else if (elig[LN_VFIQ]) idx_d = IDX_W'(CODE_VFIQ);
    else if (elig[LN_VIRQ]) idx_d = IDX_W'(CODE_VIRQ);
    else if (elig[LN_VNMI]) idx_d = IDX_W'(CODE_VNMI);
    else                    take_d = 1'b0;
    work_d = !pwr_off_i && ((|pend_i) || side_pend_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      idx_o  <= '0;
      work_o <= 1'b0;
    end else begin
      take_o <= take_d;
      idx_o  <= idx_d;
      work_o <= work_d;
    end
  end

  AST_NMI_BEATS_FIQ: assert property (@(posedge clk) disable iff (rst)
    (take_o && idx_o == IDX_W'(CODE_FIQ)) |-> $past(!(pend_i[LN_NMI] && allow_i[CL_NMI]))); // R5

  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    $past(pend_i == '0) |-> !take_o); // R9
endmodule

// File: rtl/excp_select.sv
module excp_select
  import excp_sel_pkg::*;
#(
  parameter int NUM_LVL  = 4,
  parameter int LVL_W    = $clog2(NUM_LVL),
  parameter int IDX_W    = 6,
  parameter bit FEAT_NMI = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_LINES-1:0]     irq_lines_i,
  input  logic                     vserr_req_i,
  input  logic                     exit_req_i,
  input  logic                     pwr_off_i,
  input  logic [LVL_W-1:0]         cur_lvl_i,
  input  logic [NUM_CLS*LVL_W-1:0] tgt_lvl_i,
  input  logic                     irq_mask_i,
  input  logic                     fiq_mask_i,
  input  logic                     allint_i,
  input  logic                     sp_sel_i,
  input  logic [NUM_LVL-1:0]       nmi_ctl_i,
  input  logic [NUM_LVL-1:0]       spmask_ctl_i,
  output logic                     take_o,
  output logic [IDX_W-1:0]         excp_idx_o,
  output logic                     has_work_o
);
  logic [NUM_LINES-1:0] pend;
  logic                 side_pend;
  logic [NUM_CLS-1:0]   allow;

  excp_pend #(.FEAT_NMI(FEAT_NMI)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .lines_i    (irq_lines_i),
    .vserr_i    (vserr_req_i),
    .exit_i     (exit_req_i),
    .pend_o     (pend),
    .side_pend_o(side_pend)
  );

  excp_mask #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .FEAT_NMI(FEAT_NMI)) u_mask (
    .cur_lvl_i   (cur_lvl_i),
    .tgt_lvl_i   (tgt_lvl_i),
    .irq_mask_i  (irq_mask_i),
    .fiq_mask_i  (fiq_mask_i),
    .allint_i    (allint_i),
    .sp_sel_i    (sp_sel_i),
    .nmi_ctl_i   (nmi_ctl_i),
    .spmask_ctl_i(spmask_ctl_i),
    .allow_o     (allow)
  );

  excp_prio #(.IDX_W(IDX_W), .FEAT_NMI(FEAT_NMI)) u_prio (
    .clk        (clk),
    .rst        (rst),
    .pend_i     (pend),
    .side_pend_i(side_pend),
    .allow_i    (allow),
    .pwr_off_i  (pwr_off_i),
    .take_o     (take_o),
    .idx_o      (excp_idx_o),
    .work_o     (has_work_o)
  );

  AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (rst)
    (take_o && excp_idx_o == IDX_W'(CODE_IRQ)) |-> $past(!irq_mask_i)); // R3

  AST_FIQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (rst)
    (take_o && excp_idx_o == IDX_W'(CODE_FIQ)) |-> $past(!fiq_mask_i)); // R3

  AST_NMI_NOT_LOWER: assert property (@(posedge clk) disable iff (rst)
    (take_o && excp_idx_o == IDX_W'(CODE_NMI)) |->
      $past(tgt_lvl_i[CL_NMI*LVL_W +: LVL_W] >= cur_lvl_i)); // R4

  AST_NO_WORK_POWERED_OFF: assert property (@(posedge clk) disable iff (rst)
    has_work_o |-> $past(!pwr_off_i)); // R7

  AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!take_o && !has_work_o)); // R1

  generate
    if (!FEAT_NMI) begin : g_no_feat_chk
      AST_NO_NMI_INDEX: assert property (@(posedge clk) disable iff (rst)
        !(take_o && (excp_idx_o == IDX_W'(CODE_NMI) || excp_idx_o == IDX_W'(CODE_VNMI)))); // R6
    end
  endgenerate
endmodule

// File: tb/excp_select_tb_top.sv
module excp_select_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int LW = 2;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [5:0]    lines = '0;
  logic          vserr = 1'b0, exitr = 1'b0, pwr_off = 1'b0;
  logic [LW-1:0] cur = '0;
  logic [3*LW-1:0] tgt = '0;
  logic          imask = 1'b0, fmask = 1'b0, allint = 1'b0, spsel = 1'b0;
  logic [NL-1:0] nctl = '0, spctl = '0;

  logic          take_a, take_b, work_a, work_b;
  logic [IW-1:0] idx_a, idx_b;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excp_select #(.NUM_LVL(NL), .IDX_W(IW), .FEAT_NMI(1'b1)) dut_i (
    .clk(clk), .rst(rst), .irq_lines_i(lines), .vserr_req_i(vserr), .exit_req_i(exitr),
    .pwr_off_i(pwr_off), .cur_lvl_i(cur), .tgt_lvl_i(tgt), .irq_mask_i(imask),
    .fiq_mask_i(fmask), .allint_i(allint), .sp_sel_i(spsel), .nmi_ctl_i(nctl),
    .spmask_ctl_i(spctl), .take_o(take_a), .excp_idx_o(idx_a), .has_work_o(work_a));

  excp_select #(.NUM_LVL(NL), .IDX_W(IW), .FEAT_NMI(1'b0)) dut_nonmi_i (
    .clk(clk), .rst(rst), .irq_lines_i(lines), .vserr_req_i(vserr), .exit_req_i(exitr),
    .pwr_off_i(pwr_off), .cur_lvl_i(cur), .tgt_lvl_i(tgt), .irq_mask_i(imask),
    .fiq_mask_i(fmask), .allint_i(allint), .sp_sel_i(spsel), .nmi_ctl_i(nctl),
    .spmask_ctl_i(spctl), .take_o(take_b), .excp_idx_o(idx_b), .has_work_o(work_b));

  // Behavioural reference: search lines in priority order, first acceptable wins.
  function automatic logic [7:0] predict(bit feat, logic [5:0] p, logic side);
    int order[6] = '{4, 1, 0, 3, 2, 5};
    int codes[6] = '{5, 6, 14, 15, 26, 27};
    logic [7:0] r = '0;
    bit found = 0;
    logic [5:0] en = feat ? 6'h3F : 6'h0F;
    foreach (order[k]) begin
      int ln = order[k];
      bit ok = 0;
      if (!found && p[ln] && en[ln]) begin
        if (ln == 2 || ln == 3 || ln == 5) ok = 1;
        else begin
          int cls = (ln == 4) ? 2 : ln;
          int t = int'(tgt[cls*LW +: LW]);
          bit blk = feat && (t == int'(cur)) &&
                    ((nctl[t] && allint) || (spctl[t] && spsel));
          if (t < int'(cur)) ok = 0;
          else if (ln == 0) ok = !imask && !blk;
          else if (ln == 1) ok = !fmask && !blk;
          else ok = !blk;
        end
        if (ok) begin
          found = 1;
          r[6] = 1'b1;
          r[5:0] = 6'(codes[ln]);
        end
      end
    end
    r[7] = !pwr_off && ((|(p & en)) || side);
    return r;
  endfunction

  logic [5:0] m_pend = '0;
  logic       m_side = 1'b0;
  logic [7:0] exp_a = '0, exp_b = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_pend <= '0; m_side <= 1'b0; exp_a <= '0; exp_b <= '0;
    end else begin
      exp_a  <= predict(1'b1, m_pend, m_side);
      exp_b  <= predict(1'b0, m_pend, m_side);
      m_pend <= lines;
      m_side <= vserr | exitr;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp += 2;
      if ({work_a, take_a, idx_a} !== exp_a) begin
        n_bad++;
        $display("FAIL %s feat=1 t=%0t actual work/take/idx=%b/%b/%0d expected %b/%b/%0d",
                 tag, $time, work_a, take_a, idx_a, exp_a[7], exp_a[6], exp_a[5:0]);
      end
      if ({work_b, take_b, idx_b} !== exp_b) begin
        n_bad++;
        $display("FAIL %s feat=0 t=%0t actual work/take/idx=%b/%b/%0d expected %b/%b/%0d",
                 tag, $time, work_b, take_b, idx_b, exp_b[7], exp_b[6], exp_b[5:0]);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset with everything requested
    tag = "R1"; lines = 6'h3F; vserr = 1; cyc(3);
    @(negedge clk); rst = 0; lines = '0; vserr = 0; cyc(3);

    // R2: NMI mask condition at equal levels
    tag = "R2"; cur = 2'd1; tgt = {2'd1, 2'd1, 2'd1};
    nctl = 4'b0010; allint = 1; lines = 6'b010000; cyc(3);
    allint = 0; cyc(3);
    spctl = 4'b0010; spsel = 1; cyc(3);
    spctl = 4'b0100; cyc(3);
    cur = 2'd0; spctl = 4'b0010; allint = 1; cyc(3);
    cur = 2'd1; nctl = 4'b0100; allint = 1; spsel = 0; cyc(3);

    // R3: IRQ/FIQ gated by own mask and by the NMI condition
    tag = "R3"; nctl = '0; spctl = '0; allint = 0; spsel = 0;
    lines = 6'b000011; imask = 1; fmask = 1; cyc(3);
    fmask = 0; cyc(3);
    fmask = 1; imask = 0; cyc(3);
    fmask = 0; spctl = 4'b0010; spsel = 1; cyc(3);
    lines = 6'b001011; cyc(3);
    spctl = '0; spsel = 0;

    // R4: target below current level
    tag = "R4"; cur = 2'd3; tgt = {2'd2, 2'd1, 2'd0}; lines = 6'b010011; cyc(3);
    tgt = {2'd3, 2'd0, 2'd3}; cyc(3);

    // R5: NMI ahead of FIQ
    tag = "R5"; cur = 2'd0; tgt = {2'd1, 2'd1, 2'd1}; lines = 6'b111111; cyc(3);

    // R8: walk the priority chain downward
    tag = "R8"; lines = 6'b101111; cyc(2); lines = 6'b101101; cyc(2);
    lines = 6'b101100; cyc(2); lines = 6'b100100; cyc(2);
    lines = 6'b100000; cyc(2);

    // R6: feature-gated lines alone
    tag = "R6"; lines = 6'b110000; cyc(3);

    // R7: has-work and power
    tag = "R7"; lines = '0; exitr = 1; cyc(3); pwr_off = 1; cyc(3);
    exitr = 0; lines = 6'b000001; cyc(3); pwr_off = 0; cyc(2); lines = '0;

    // R9: level deassert
    tag = "R9"; lines = 6'b000010; cyc(1); lines = '0; cyc(4);

    // Random mix across all inputs (R8 ordering under broad stimulus)
    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      lines   = 6'($urandom);
      vserr   = ($urandom % 8) == 0;
      exitr   = ($urandom % 8) == 0;
      pwr_off = ($urandom % 6) == 0;
      cur     = LW'($urandom);
      tgt     = (3*LW)'($urandom);
      imask   = 1'($urandom); fmask = 1'($urandom);
      allint  = 1'($urandom); spsel = 1'($urandom);
      nctl    = NL'($urandom); spctl = NL'($urandom);
      cyc(1);
    end
    cyc(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule